// File: doc/BRIEF.md
# Multi-Channel Threshold Watchdog

This block watches four sample channels against one shared window of signed 24-bit limits. It takes a conversion-done strobe and a data word for each channel. When a strobe arrives on a channel that is enabled in the watch mask, the block compares the value once with the upper and lower limits. It can compare either the raw word or a corrected value. The corrected value is the word minus a programmable offset, followed by an arithmetic right shift.

A value above the upper limit latches that channel's high event flag. A value below the lower limit latches its low event flag. Each flag stays set until software strobes its own write-one-to-clear bit. A summary flag shows that at least one of the eight event flags is set. Four break lines carry the latched events onward to protection logic. A high-event mask and a separate low-event mask select which break lines the events drive.

Top module: `chan_level_guard`

## Requirements
- R1: While `rstN` is low, all event flags, `anyFlag` and all `brk` lines are 0.
- R2: Channel c takes its word from `convData[c]`. A cycle with `convDone[c]`=1 and `watchMask[c]`=1 sets `hiFlag[c]` at the next rising clock edge if the compared value is strictly greater than `hiThresh`, using signed two's-complement comparison. A value equal to the threshold does not set the flag.
- R3: Under the same conditions, `loFlag[c]` sets if the compared value is strictly less than `loThresh` (signed). A value equal to the threshold does not set the flag.
- R4: A channel whose `watchMask` bit is 0, or whose `convDone` bit is 0, sets no flag in that cycle, whatever its data.
- R5: With `adjEn`=0 the compared value is the raw word. With `adjEn`=1 it is (word − `offsetVal`), formed at 25-bit signed precision so that it never wraps, then arithmetically shifted right by `shiftAmt` (0 to 31), which rounds toward minus infinity.
- R6: A set flag holds until its own clear bit (`clrHi[c]` or `clrLo[c]`) is 1 at a rising edge. It then reads 0 after that edge. Clearing one flag leaves every other flag unchanged.
- R7: If a flag's set condition and its clear bit occur in the same cycle, the flag is 1 after the edge.
- R8: `anyFlag` is 1 exactly when at least one of the eight event flags is 1. It follows the flags in the same cycle.
- R9: `brk[b]` = (any `hiFlag` set AND `hiBrkMask[b]`) OR (any `loFlag` set AND `loBrkMask[b]`). It is combinational from the flags and the masks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| convDone | input | 4 | Per-channel end-of-conversion strobe |
| convData | input | 4x24 | Per-channel signed data word |
| watchMask | input | 4 | Channels whose results are compared |
| adjEn | input | 1 | 1: compare offset-corrected, shifted value |
| offsetVal | input | 24 | Signed offset subtracted before the shift |
| shiftAmt | input | 5 | Arithmetic right shift amount |
| hiThresh | input | 24 | Signed upper limit |
| loThresh | input | 24 | Signed lower limit |
| clrHi | input | 4 | Write-one-to-clear strobes for the high flags |
| clrLo | input | 4 | Write-one-to-clear strobes for the low flags |
| hiBrkMask | input | 4 | Break lines driven by high events |
| loBrkMask | input | 4 | Break lines driven by low events |
| hiFlag | output | 4 | Latched per-channel high events |
| loFlag | output | 4 | Latched per-channel low events |
| anyFlag | output | 1 | OR of all event flags |
| brk | output | 4 | Break outputs |

## Verification
A new event and a software clear can hit the same flag in the same cycle, and the flag must come out set. The bench provokes this directly on channel 3: in one cycle it raises the conversion strobe with an over-limit word and also raises that flag's clear bit. The following cycle must read the flag as 1, and a lone clear in the next cycle must drop it. The random phase then mixes clear strobes and conversions freely, and a behavioural reference model judges every cycle.

// File: rtl/lvl_guard_pkg.sv
package lvl_guard_pkg;

  localparam int NUM_CH  = 4;
  localparam int DATA_W  = 24;
  localparam int SHIFT_W = 5;
  localparam int NUM_BRK = 4;

  // Compare results handed from the datapath to the flag control.
  typedef struct packed {
    logic [NUM_CH-1:0] hiHit;
    logic [NUM_CH-1:0] loHit;
  } hitStrb_t;

endpackage

// File: rtl/lvl_guard_dp.sv
module lvl_guard_dp
  import lvl_guard_pkg::*;
#(
  parameter int NCH = NUM_CH,
  parameter int DW  = DATA_W,
  parameter int SHW = SHIFT_W
) (
  input  logic [NCH-1:0]         convDone,
  input  logic [NCH-1:0]         watchMask,
  input  logic [NCH-1:0][DW-1:0] convData,
  input  logic                   adjEn,
  input  logic [DW-1:0]          offsetVal,
  input  logic [SHW-1:0]         shiftAmt,
  input  logic [DW-1:0]          hiThresh,
  input  logic [DW-1:0]          loThresh,
  output hitStrb_t               strb
);

  // One extra bit keeps the offset subtraction from wrapping.
  localparam int EW = DW + 1;

  logic signed [EW-1:0] hiExt;
  logic signed [EW-1:0] loExt;
  logic signed [EW-1:0] offExt;
  logic [NCH-1:0]       hiHitV;
  logic [NCH-1:0]       loHitV;

  assign hiExt  = {hiThresh[DW-1], hiThresh};
  assign loExt  = {loThresh[DW-1], loThresh};
  assign offExt = {offsetVal[DW-1], offsetVal};

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    logic signed [EW-1:0] rawExt;
    logic signed [EW-1:0] diff;
    logic signed [EW-1:0] scaled;
    logic                 armed;

    assign rawExt = {convData[c][DW-1], convData[c]};
    assign diff   = rawExt - offExt;
    assign scaled = adjEn ? (diff >>> shiftAmt) : rawExt;
    assign armed  = convDone[c] & watchMask[c];

    assign hiHitV[c] = armed & (scaled > hiExt);
    assign loHitV[c] = armed & (scaled < loExt);
  end

  assign strb.hiHit = hiHitV;
  assign strb.loHit = loHitV;

endmodule

// File: rtl/lvl_guard_ctl.sv
module lvl_guard_ctl
  import lvl_guard_pkg::*;
#(
  parameter int NCH  = NUM_CH,
  parameter int NBRK = NUM_BRK
) (
  input  logic            clk,
  input  logic            rstN,
  input  hitStrb_t        strb,
  input  logic [NCH-1:0]  clrHi,
  input  logic [NCH-1:0]  clrLo,
  input  logic [NBRK-1:0] hiBrkMask,
  input  logic [NBRK-1:0] loBrkMask,
  output logic [NCH-1:0]  hiFlag,
  output logic [NCH-1:0]  loFlag,
  output logic            anyFlag,
  output logic [NBRK-1:0] brk
);

  logic [NCH-1:0] hiQ;
  logic [NCH-1:0] loQ;
  logic           hiAny;
  logic           loAny;

  // Set has priority over a clear in the same cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiQ <= '0;
      loQ <= '0;
    end else begin
      hiQ <= strb.hiHit | (hiQ & ~clrHi);
      loQ <= strb.loHit | (loQ & ~clrLo);
    end
  end

  assign hiAny   = |hiQ;
  assign loAny   = |loQ;
  assign anyFlag = hiAny | loAny;
  assign hiFlag  = hiQ;
  assign loFlag  = loQ;

  for (genvar b = 0; b < NBRK; b++) begin : g_brk
    assign brk[b] = (hiAny & hiBrkMask[b]) | (loAny & loBrkMask[b]);
  end

endmodule

// File: rtl/chan_level_guard.sv
module chan_level_guard
  import lvl_guard_pkg::*;
#(
  parameter int NCH  = NUM_CH,
  parameter int DW   = DATA_W,
  parameter int SHW  = SHIFT_W,
  parameter int NBRK = NUM_BRK
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NCH-1:0]         convDone,
  input  logic [NCH-1:0][DW-1:0] convData,
  input  logic [NCH-1:0]         watchMask,
  input  logic                   adjEn,
  input  logic [DW-1:0]          offsetVal,
  input  logic [SHW-1:0]         shiftAmt,
  input  logic [DW-1:0]          hiThresh,
  input  logic [DW-1:0]          loThresh,
  input  logic [NCH-1:0]         clrHi,
  input  logic [NCH-1:0]         clrLo,
  input  logic [NBRK-1:0]        hiBrkMask,
  input  logic [NBRK-1:0]        loBrkMask,
  output logic [NCH-1:0]         hiFlag,
  output logic [NCH-1:0]         loFlag,
  output logic                   anyFlag,
  output logic [NBRK-1:0]        brk
);

  hitStrb_t strb;

  lvl_guard_dp #(.NCH(NCH), .DW(DW), .SHW(SHW)) u_dp (
    .convDone  (convDone),
    .watchMask (watchMask),
    .convData  (convData),
    .adjEn     (adjEn),
    .offsetVal (offsetVal),
    .shiftAmt  (shiftAmt),
    .hiThresh  (hiThresh),
    .loThresh  (loThresh),
    .strb      (strb)
  );

  lvl_guard_ctl #(.NCH(NCH), .NBRK(NBRK)) u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .clrHi     (clrHi),
    .clrLo     (clrLo),
    .hiBrkMask (hiBrkMask),
    .loBrkMask (loBrkMask),
    .hiFlag    (hiFlag),
    .loFlag    (loFlag),
    .anyFlag   (anyFlag),
    .brk       (brk)
  );

endmodule

// File: rtl/lvl_guard_chk.sv
module lvl_guard_chk
  import lvl_guard_pkg::*;
#(
  parameter int NCH  = NUM_CH,
  parameter int DW   = DATA_W,
  parameter int NBRK = NUM_BRK
) (
  input logic            clk,
  input logic            rstN,
  input logic [NCH-1:0]  convDone,
  input logic [NCH-1:0]  watchMask,
  input logic [DW-1:0]   hiThresh,
  input logic [DW-1:0]   loThresh,
  input logic [NCH-1:0]  clrHi,
  input logic [NCH-1:0]  clrLo,
  input hitStrb_t        strb,
  input logic [NCH-1:0]  hiFlag,
  input logic [NCH-1:0]  loFlag,
  input logic            anyFlag,
  input logic [NBRK-1:0] brk
);

  // R1
  always_comb begin
    if (!rstN) begin
      reset_quiet_chk: assert (hiFlag == '0 && loFlag == '0 && !anyFlag && brk == '0);
    end
  end

  // R4
  unwatched_hi_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((hiFlag & ~$past(hiFlag) & ~$past(convDone & watchMask)) == '0));

  // R4
  unwatched_lo_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((loFlag & ~$past(loFlag) & ~$past(convDone & watchMask)) == '0));

  // R6
  sticky_hi_chk: assert property (@(posedge clk) disable iff (!rstN)
    (($past(hiFlag) & ~hiFlag & ~$past(clrHi)) == '0));

  // R6
  sticky_lo_chk: assert property (@(posedge clk) disable iff (!rstN)
    (($past(loFlag) & ~loFlag & ~$past(clrLo)) == '0));

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((($past(strb.hiHit) & ~hiFlag) == '0) && (($past(strb.loHit) & ~loFlag) == '0)));

  // R2
  window_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($signed(hiThresh) >= $signed(loThresh)) |-> ((strb.hiHit & strb.loHit) == '0));

  // R9
  brk_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !anyFlag |-> (brk == '0));

  // R8
  any_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !anyFlag |-> (hiFlag == '0 && loFlag == '0));

endmodule

bind chan_level_guard lvl_guard_chk #(.NCH(NCH), .DW(DW), .NBRK(NBRK)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .convDone  (convDone),
  .watchMask (watchMask),
  .hiThresh  (hiThresh),
  .loThresh  (loThresh),
  .clrHi     (clrHi),
  .clrLo     (clrLo),
  .strb      (strb),
  .hiFlag    (hiFlag),
  .loFlag    (loFlag),
  .anyFlag   (anyFlag),
  .brk       (brk)
);

// File: tb/chan_level_guard_test.sv
`timescale 1ns/1ps
module chan_level_guard_test;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [3:0]      convDone = '0;
  logic [3:0][23:0] convData = '0;
  logic [3:0]      watchMask = 4'hF;
  logic            adjEn = 1'b0;
  logic [23:0]     offsetVal = '0;
  logic [4:0]      shiftAmt = '0;
  logic [23:0]     hiThresh = 24'd1000;
  logic [23:0]     loThresh = -24'sd1000;
  logic [3:0]      clrHi = '0;
  logic [3:0]      clrLo = '0;
  logic [3:0]      hiBrkMask = '0;
  logic [3:0]      loBrkMask = '0;
  logic [3:0]      hiFlag;
  logic [3:0]      loFlag;
  logic            anyFlag;
  logic [3:0]      brk;

  int checks = 0;
  int errors = 0;
  string curReq = "R1";

  bit mHi [4];
  bit mLo [4];

  always #2 clk = ~clk;

  chan_level_guard uut (
    .clk(clk), .rstN(rstN), .convDone(convDone), .convData(convData),
    .watchMask(watchMask), .adjEn(adjEn), .offsetVal(offsetVal),
    .shiftAmt(shiftAmt), .hiThresh(hiThresh), .loThresh(loThresh),
    .clrHi(clrHi), .clrLo(clrLo), .hiBrkMask(hiBrkMask),
    .loBrkMask(loBrkMask), .hiFlag(hiFlag), .loFlag(loFlag),
    .anyFlag(anyFlag), .brk(brk)
  );

  function automatic int sx24(logic [23:0] v);
    return int'({{8{v[23]}}, v});
  endfunction

  function automatic int cmpVal(logic [23:0] d);
    int diff;
    if (!adjEn) return sx24(d);
    diff = sx24(d) - sx24(offsetVal);
    return diff >>> shiftAmt;
  endfunction

  // Behavioural reference, updated at each rising edge.
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      foreach (mHi[i]) begin mHi[i] = 1'b0; mLo[i] = 1'b0; end
    end else begin
      for (int c = 0; c < 4; c++) begin
        bit armed;
        int v;
        armed = convDone[c] && watchMask[c];
        v = cmpVal(convData[c]);
        mHi[c] = (armed && v > sx24(hiThresh)) || (mHi[c] && !clrHi[c]);
        mLo[c] = (armed && v < sx24(loThresh)) || (mLo[c] && !clrLo[c]);
      end
    end
  end

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] packHi();
    logic [3:0] r;
    for (int c = 0; c < 4; c++) r[c] = mHi[c];
    return r;
  endfunction

  function automatic logic [3:0] packLo();
    logic [3:0] r;
    for (int c = 0; c < 4; c++) r[c] = mLo[c];
    return r;
  endfunction

  // Per-cycle comparison with the model.
  always @(posedge clk) begin
    logic [3:0] eh, el, eb;
    #1;
    eh = packHi();
    el = packLo();
    for (int b = 0; b < 4; b++)
      eb[b] = ((|eh) & hiBrkMask[b]) | ((|el) & loBrkMask[b]);
    check(curReq, "hiFlag", 32'(hiFlag), 32'(eh));
    check(curReq, "loFlag", 32'(loFlag), 32'(el));
    check(curReq, "anyFlag", 32'(anyFlag), 32'((|eh) | (|el)));
    check(curReq, "brk", 32'(brk), 32'(eb));
  end

  task automatic pulse(int ch, int data);
    @(negedge clk);
    convDone[ch] = 1'b1;
    convData[ch] = 24'(data);
    @(negedge clk);
    convDone = '0;
  endtask

  task automatic clearStrobe(logic [3:0] h, logic [3:0] l);
    @(negedge clk);
    clrHi = h;
    clrLo = l;
    @(negedge clk);
    clrHi = '0;
    clrLo = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    curReq = "R1";
    repeat (3) @(negedge clk);
    #1;
    check("R1", "reset flags", 32'({hiFlag, loFlag, anyFlag, brk}), 32'd0);
    @(negedge clk);
    rstN = 1'b1;

    curReq = "R2";
    pulse(0, 1000);
    check("R2", "equal to high limit", 32'(hiFlag), 32'h0);
    pulse(0, 1001);
    check("R2", "above high limit", 32'(hiFlag), 32'h1);

    curReq = "R3";
    pulse(1, -1000);
    check("R3", "equal to low limit", 32'(loFlag), 32'h0);
    pulse(1, -1001);
    check("R3", "below low limit", 32'(loFlag), 32'h2);

    curReq = "R4";
    watchMask = 4'b1011;
    pulse(2, 5000);
    check("R4", "unwatched channel", 32'(hiFlag), 32'h1);
    watchMask = 4'hF;
    @(negedge clk);
    convData[2] = 24'd6000;
    @(negedge clk);
    check("R4", "no strobe", 32'(hiFlag), 32'h1);

    curReq = "R6";
    clearStrobe(4'b0001, 4'b0000);
    check("R6", "hi cleared", 32'(hiFlag), 32'h0);
    check("R6", "lo untouched", 32'(loFlag), 32'h2);

    curReq = "R7";
    @(negedge clk);
    convDone[3] = 1'b1;
    convData[3] = 24'd2000;
    clrHi = 4'b1000;
    @(negedge clk);
    convDone = '0;
    clrHi = '0;
    check("R7", "set beats clear", 32'(hiFlag), 32'h8);
    clearStrobe(4'b1000, 4'b0000);
    check("R7", "lone clear", 32'(hiFlag), 32'h0);

    curReq = "R8";
    clearStrobe(4'b0000, 4'b0010);
    check("R8", "all clear any", 32'(anyFlag), 32'h0);

    curReq = "R5";
    adjEn = 1'b1;
    offsetVal = 24'd500;
    shiftAmt = 5'd2;
    pulse(0, 4500);
    check("R5", "adjusted equal high", 32'(hiFlag), 32'h0);
    pulse(0, 4504);
    check("R5", "adjusted above high", 32'(hiFlag), 32'h1);
    pulse(1, -3500);
    check("R5", "adjusted equal low", 32'(loFlag), 32'h0);
    pulse(1, -3504);
    check("R5", "floor rounding low", 32'(loFlag), 32'h2);
    clearStrobe(4'hF, 4'hF);
    offsetVal = 24'h7FFFFF;
    shiftAmt = 5'd0;
    pulse(2, -8388608);
    check("R5", "no wrap negative", 32'(loFlag), 32'h4);
    offsetVal = 24'h800000;
    pulse(2, 8388607);
    check("R5", "no wrap positive", 32'(hiFlag), 32'h4);

    curReq = "R9";
    @(negedge clk);
    hiBrkMask = 4'b0011;
    loBrkMask = 4'b0110;
    #1;
    check("R9", "both routed", 32'(brk), 32'h7);
    clearStrobe(4'hF, 4'h0);
    check("R9", "low only", 32'(brk), 32'h6);
    check("R8", "low keeps any", 32'(anyFlag), 32'h1);
    clearStrobe(4'h0, 4'hF);
    check("R9", "none routed", 32'(brk), 32'h0);

    curReq = "R7";
    adjEn = 1'b0;
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      convDone = 4'($urandom);
      for (int c = 0; c < 4; c++) convData[c] = 24'($urandom_range(0, 4000) - 2000);
      clrHi = 4'($urandom) & 4'($urandom);
      clrLo = 4'($urandom) & 4'($urandom);
      if (n % 50 == 0) begin
        watchMask = 4'($urandom);
        hiBrkMask = 4'($urandom);
        loBrkMask = 4'($urandom);
        adjEn = 1'($urandom);
        offsetVal = 24'($urandom_range(0, 600) - 300);
        shiftAmt = 5'($urandom_range(0, 3));
      end
    end
    @(negedge clk);
    convDone = '0;
    clrHi = '0;
    clrLo = '0;
    @(negedge clk);
    @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule